// File: doc/BRIEF.md
# Whole-Packet Line-Data FIFO with Event Status

This block buffers the data recovered from the vertical blanking interval of a video signal. Each video line produces at most one packet, made of a header and a payload whose size depends on the data service carried on that line. A closed-caption packet is only a header plus two bytes, while a teletext packet is many times longer. The writer gives the total packet length together with the first byte. The block admits the packet only if all of it fits in the free space at that moment. A packet that does not fit is discarded in full, down to its end marker, and nothing of it reaches storage.

A host drains the stored bytes one at a time through a read port with one cycle of latency. Alongside the storage the block keeps a bank of sticky event bits. These cover packet refusal, fill-level threshold crossing and a data-available bit for each of seven services. Each bit is cleared by writing one to it. The raw bits are visible unmasked. An enable mask selects which of them appear in the masked view, and the OR of that view drives a single interrupt line. A refusal does not block the FIFO: a later, shorter packet that fits is accepted as usual.

Top module: `vbi_pkt_fifo`

## Requirements
- R1: On the first byte of a packet (wr_valid and wr_first high), the packet is stored whole when wr_len is no larger than DEPTH minus fill_level at that cycle. Otherwise none of its bytes are stored, up to and including the byte marked wr_last.
- R2: A refused packet sets raw_status bit 8 (overflow) on the clock edge of its first byte.
- R3: After the overflow bit is set, a later packet that fits the free space is stored and read back normally.
- R4: raw_status bit 7 (threshold) is set on the edge where fill_level moves from below `thresh` to at or above it.
- R5: A one-cycle pulse on svc_event[i] sets raw_status[i]. The bit positions are: 0 teletext, 1 wide-screen signalling, 2 programme delivery, 3 vertical interval timecode, 4 caption field 1, 5 caption field 2, 6 line-number match.
- R6: Every raw_status bit stays set until a cycle with the matching irq_clear bit high. A clear has no effect on other bits. When a set and a clear reach the same bit in the same cycle, the bit stays set.
- R7: masked_status shows raw_status only where irq_mask is 1, and irq is high exactly when any masked_status bit is high. With the mask unchanged, irq stays high until every enabled set bit is cleared.
- R8: A read (rd_en) of an empty FIFO returns rd_data = 0 on the next cycle and leaves fill_level unchanged.
- R9: A read and a stored write in the same cycle leave fill_level unchanged.
- R10: Stored bytes come out in write order. A byte appears on rd_data in the cycle after the rd_en cycle that pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A packet byte is present |
| wr_first | input | 1 | The byte is the first byte of a packet |
| wr_last | input | 1 | The byte is the last byte of a packet |
| wr_len | input | CW | Total packet length, sampled with wr_first |
| wr_data | input | DW | Packet byte |
| rd_en | input | 1 | Host read request |
| rd_data | output | DW | Read byte, valid the cycle after rd_en |
| fill_level | output | CW | Number of stored bytes |
| thresh | input | CW | Fill threshold for status bit 7 |
| svc_event | input | 7 | Per-service data-available pulses |
| irq_mask | input | 9 | Enable for each status bit |
| irq_clear | input | 9 | Write-one-to-clear pulses |
| raw_status | output | 9 | Sticky unmasked event bits |
| masked_status | output | 9 | Event bits after the mask |
| irq | output | 1 | Interrupt, OR of masked_status |

## Verification
A wrong admission flag shows up in the very next drain. Bytes from a refused packet appear in the read stream, or bytes of an accepted one go missing, and the in-order comparison catches the first wrong byte. A fill count that drifts by one shows on fill_level on the next edge. It also moves the threshold bit one byte early or late and turns the fit decision for a packet that exactly fills the space. A status bit that loses its stickiness, ignores the same-cycle precedence rule or leaks through the mask is visible on raw_status, masked_status or irq one cycle after the pulse.

// File: rtl/vbi_pkt_pkg.sv
`timescale 1ns/1ps
package vbi_pkt_pkg;
   localparam int NUM_SVC = 7;
   localparam int NUM_EV  = 9;
   // status bit positions
   localparam int EV_TTX  = 0;
   localparam int EV_WSS  = 1;
   localparam int EV_PDC  = 2;
   localparam int EV_TC   = 3;
   localparam int EV_CC1  = 4;
   localparam int EV_CC2  = 5;
   localparam int EV_LINE = 6;
   localparam int EV_THR  = 7;
   localparam int EV_OVF  = 8;
endpackage

// File: rtl/vpf_admit.sv
`timescale 1ns/1ps
// Whole-packet admission: decides at the first byte, then keeps or drops the rest.
module vpf_admit #(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic          wr_first,
   input  logic          wr_last,
   input  logic [CW-1:0] wr_len,
   input  logic [CW-1:0] count,
   output logic          push,
   output logic          refuse
);
   logic [CW-1:0] free_now;
   logic          fits;
   logic          keep_q;
   logic          keep_now;

   assign free_now = CW'(DEPTH) - count;
   assign fits     = (wr_len <= free_now);
   assign keep_now = wr_first ? fits : keep_q;
   assign push     = wr_valid && keep_now && (count != CW'(DEPTH));
   assign refuse   = wr_valid && wr_first && !fits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keep_q <= 1'b0;
      end else if (wr_valid) begin
         keep_q <= wr_last ? 1'b0 : keep_now;
      end
   end
endmodule

// File: rtl/vpf_store.sv
`timescale 1ns/1ps
// Circular byte store with fill count and registered read port.
module vpf_store #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          rd_req,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_nxt
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic          pop;

   assign pop       = rd_req && (count != '0);
   assign count_nxt = count + CW'(push) - CW'(pop);

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         dout  <= '0;
      end else begin
         count <= count_nxt;
         if (push) begin
            wptr <= wptr + 1'b1;
         end
         if (pop) begin
            rptr <= rptr + 1'b1;
         end
         if (rd_req) begin
            dout <= pop ? mem[rptr] : '0;
         end
      end
   end
endmodule

// File: rtl/vpf_irq.sv
`timescale 1ns/1ps
// Sticky write-one-to-clear event bank with mask and interrupt reduction.
module vpf_irq #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_ev,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] mask,
   output logic [N-1:0] raw,
   output logic [N-1:0] masked,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            raw[i] <= 1'b0;
         end else if (set_ev[i]) begin
            raw[i] <= 1'b1;
         end else if (clr[i]) begin
            raw[i] <= 1'b0;
         end
      end
      assign masked[i] = raw[i] & mask[i];
   end

   assign irq = |masked;
endmodule

// File: rtl/vbi_pkt_fifo.sv
`timescale 1ns/1ps
module vbi_pkt_fifo
   import vbi_pkt_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              wr_first,
   input  logic              wr_last,
   input  logic [CW-1:0]     wr_len,
   input  logic [DW-1:0]     wr_data,
   input  logic              rd_en,
   output logic [DW-1:0]     rd_data,
   output logic [CW-1:0]     fill_level,
   input  logic [CW-1:0]     thresh,
   input  logic [NUM_SVC-1:0] svc_event,
   input  logic [NUM_EV-1:0] irq_mask,
   input  logic [NUM_EV-1:0] irq_clear,
   output logic [NUM_EV-1:0] raw_status,
   output logic [NUM_EV-1:0] masked_status,
   output logic              irq
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 4");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic          push;
   logic          refuse;
   logic [CW-1:0] count_nxt;
   logic          thr_evt;
   logic [NUM_EV-1:0] set_vec;

   vpf_admit #(.DEPTH(DEPTH)) u_admit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(wr_valid),
      .wr_first(wr_first),
      .wr_last (wr_last),
      .wr_len  (wr_len),
      .count   (fill_level),
      .push    (push),
      .refuse  (refuse)
   );

   vpf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .din      (wr_data),
      .rd_req   (rd_en),
      .dout     (rd_data),
      .count    (fill_level),
      .count_nxt(count_nxt)
   );

   assign thr_evt = (fill_level < thresh) && (count_nxt >= thresh);
   assign set_vec = {refuse, thr_evt, svc_event};

   vpf_irq #(.N(NUM_EV)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_ev(set_vec),
      .clr   (irq_clear),
      .mask  (irq_mask),
      .raw   (raw_status),
      .masked(masked_status),
      .irq   (irq)
   );
endmodule

// File: rtl/vbi_pkt_fifo_chk.sv
`timescale 1ns/1ps
module vbi_pkt_fifo_chk
   import vbi_pkt_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_first,
   input logic [CW-1:0]     wr_len,
   input logic              rd_en,
   input logic [DW-1:0]     rd_data,
   input logic [CW-1:0]     fill_level,
   input logic [NUM_EV-1:0] raw_status,
   input logic [NUM_EV-1:0] irq_mask,
   input logic [NUM_EV-1:0] irq_clear,
   input logic [NUM_EV-1:0] masked_status,
   input logic              irq
);
   logic too_big;
   assign too_big = wr_valid && wr_first && (wr_len > (CW'(DEPTH) - fill_level));

   a_r1_no_growth_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      too_big |=> (fill_level <= $past(fill_level)));

   a_r2_refuse_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      too_big |=> raw_status[EV_OVF]);

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_status & $past(raw_status & ~irq_clear)) == $past(raw_status & ~irq_clear)));

   a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && ($past(irq_clear & masked_status) == '0) && $stable(irq_mask)) |-> irq);

   a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && fill_level == '0) |=> (rd_data == '0));

   a_r9_level_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((fill_level == $past(fill_level)) || (fill_level == $past(fill_level) + 1'b1)
                || (fill_level + 1'b1 == $past(fill_level))));

   a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= CW'(DEPTH));
endmodule

bind vbi_pkt_fifo vbi_pkt_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_valid     (wr_valid),
   .wr_first     (wr_first),
   .wr_len       (wr_len),
   .rd_en        (rd_en),
   .rd_data      (rd_data),
   .fill_level   (fill_level),
   .raw_status   (raw_status),
   .irq_mask     (irq_mask),
   .irq_clear    (irq_clear),
   .masked_status(masked_status),
   .irq          (irq)
);

// File: tb/tb_vbi_pkt_fifo.sv
`timescale 1ns/1ps
module tb_vbi_pkt_fifo;
   localparam int DEPTH = 16;
   localparam int CW = $clog2(DEPTH) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0, wr_first = 1'b0, wr_last = 1'b0;
   logic [CW-1:0] wr_len = '0;
   logic [7:0] wr_data = '0;
   logic rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [CW-1:0] fill_level;
   logic [CW-1:0] thresh = CW'(8);
   logic [6:0] svc_event = '0;
   logic [8:0] irq_mask = '0, irq_clear = '0;
   logic [8:0] raw_status, masked_status;
   logic irq;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   vbi_pkt_fifo #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_first(wr_first),
      .wr_last(wr_last), .wr_len(wr_len), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .fill_level(fill_level), .thresh(thresh),
      .svc_event(svc_event), .irq_mask(irq_mask), .irq_clear(irq_clear),
      .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every read (R10, R8)
   initial begin
      forever begin
         logic seen;
         logic [7:0] e;
         @(posedge clk);
         seen = rd_en && rst_n;
         #1;
         if (seen) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
            chk(rd_data == e, "R10/R8 read byte", rd_data, e);
         end
      end
   end

   // driver: bench decides the fit from its own model (R1)
   task automatic send_pkt(input int len, input logic [7:0] base);
      bit fits;
      fits = (DEPTH - exp_q.size()) >= len;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i > 0 && fits) exp_q.push_back(8'(base + i - 1));
         wr_valid = 1'b1; wr_first = (i == 0); wr_last = (i == len - 1);
         wr_len = CW'(len); wr_data = 8'(base + i);
      end
      @(negedge clk);
      if (fits) exp_q.push_back(8'(base + len - 1));
      wr_valid = 1'b0; wr_first = 1'b0; wr_last = 1'b0;
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_en = 1'b1;
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [6:0] ev, input logic [8:0] cl);
      @(negedge clk);
      svc_event = ev; irq_clear = cl;
      @(negedge clk);
      svc_event = '0; irq_clear = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fill_level == 0, "reset level", fill_level, 0);
      chk(raw_status == 0, "reset status", raw_status, 0);
      chk(irq == 1'b0, "reset irq", irq, 0);
      chk(rd_data == 0, "reset rd_data", rd_data, 0);

      // R1/R4: long packet accepted, threshold 8 crossed
      send_pkt(12, 8'h40);
      chk(fill_level == 12, "R1 long packet stored", fill_level, 12);
      chk(raw_status[7] == 1'b1, "R4 threshold crossed", raw_status[7], 1);
      chk(raw_status[8] == 1'b0, "R2 no overflow yet", raw_status[8], 0);
      // R1/R2: second long packet does not fit (free 4)
      send_pkt(12, 8'h60);
      chk(fill_level == 12, "R1 refused packet not stored", fill_level, 12);
      chk(raw_status[8] == 1'b1, "R2 overflow set", raw_status[8], 1);
      // R3: short caption packet fits after overflow
      send_pkt(3, 8'h20);
      chk(fill_level == 15, "R3 short packet stored", fill_level, 15);
      send_pkt(3, 8'h30);
      chk(fill_level == 15, "R1 refused with one byte free", fill_level, 15);
      // R10/R8: drain all plus one empty read
      drain(16);
      chk(fill_level == 0, "R8 level after empty read", fill_level, 0);
      chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

      // R9: concurrent read and write
      pulse('0, 9'h1FF);
      chk(raw_status == 0, "R6 clear all", raw_status, 0);
      send_pkt(3, 8'h70);
      fork
         send_pkt(3, 8'h80);
         drain(3);
      join
      chk(fill_level == 3, "R9 level with read and write", fill_level, 3);
      drain(3);
      chk(fill_level == 0, "R9 level after drain", fill_level, 0);
      chk(raw_status[7] == 1'b0, "R4 no crossing below threshold", raw_status[7], 0);

      // R5/R6: each service bit, mask all off
      for (int i = 0; i < 7; i++) begin
         pulse(7'(1 << i), '0);
         chk(raw_status == 9'(1 << i), "R5 service bit", raw_status, 1 << i);
         chk(irq == 1'b0 && masked_status == 0, "R7 masked off", masked_status, 0);
         pulse('0, 9'(1 << i));
         chk(raw_status == 0, "R6 write-one clear", raw_status, 0);
      end

      // R7: mask enables caption field 1 (bit 4) only
      irq_mask = 9'h010;
      pulse(7'h01, '0);
      chk(irq == 1'b0, "R7 disabled bit no irq", irq, 0);
      pulse(7'h10, '0);
      chk(masked_status == 9'h010, "R7 masked view", masked_status, 9'h010);
      chk(irq == 1'b1, "R7 irq raised", irq, 1);
      pulse('0, 9'h001);
      chk(irq == 1'b1 && raw_status == 9'h010, "R7 irq held", raw_status, 9'h010);
      pulse('0, 9'h010);
      chk(irq == 1'b0, "R7 irq dropped", irq, 0);

      // R6: set wins over clear in the same cycle
      pulse(7'h04, 9'h004);
      chk(raw_status == 9'h004, "R6 set wins", raw_status, 9'h004);
      pulse('0, 9'h004);
      chk(raw_status == 0, "R6 cleared after", raw_status, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule